// File: doc/BRIEF.md
# Interrupt mode and enable controller

This block keeps the interrupt state of an 8-bit processor core: two enable flip-flops (a live enable and a saved copy), a two-bit vectoring mode and an 8-bit vector base register. The instruction decoder sends it single-cycle strobes for enable, disable, return-from-interrupt, set-mode and load-base. The block looks at the maskable and non-maskable request lines only when the core signals an instruction boundary. When it accepts a request, it raises an acknowledge strobe. One cycle later it reports where execution continues.

A maskable request is honoured only when the live enable is set and the instruction that set it is not the one just finishing. A non-maskable request is captured on its rising edge and is always honoured, ahead of any maskable request. The target depends on the mode. It can be a fixed handler address. It can be a table pointer whose high byte is the base register and whose low byte comes from the device. It can also be the device byte itself, which the core then executes as an instruction. While the core is halted, an accepted request also pulses a halt-release output.

The decoder must not raise a command strobe in the same cycle as a boundary pulse. The core must not raise a boundary pulse during an acknowledge cycle. The block ignores such a pulse.

Top module: `irq_mode_ctrl`

## Requirements
- R1: After reset both enables are clear, the mode is the device-byte mode and the base register is 00h. No strobe or vector output is active, and vec_addr reads 0000h.
- R2: The enable command sets both enable flip-flops and the disable command clears both. A maskable request (int_req high at a boundary) is accepted only while the live enable is set.
- R3: A maskable request is not accepted at the first boundary after an enable command. It is accepted at the next boundary.
- R4: The set-mode command takes im_field, which is bits 4:3 of the mode instruction's second opcode byte. The value 2'b10 selects the fixed mode, 2'b11 the table mode, and 2'b00 or 2'b01 the device-byte mode.
- R5: In device-byte mode, an accepted maskable request gives vec_kind 2 (execute byte) and vec_addr equal to the device byte zero-extended.
- R6: In fixed mode, an accepted maskable request gives vec_kind 0 (jump) and vec_addr 0038h.
- R7: In table mode, an accepted maskable request gives vec_kind 1 (table pointer) and vec_addr {base, device byte}. The load-base command writes i_wdata into the base register.
- R8: Accepting a maskable request clears both enables, so a held request is not taken again and a following return does not re-enable.
- R9: A rising edge on nmi_req is latched. It is accepted at the next boundary whatever the enables are, with vec_kind 0 and vec_addr 0066h. It clears the live enable and keeps the saved copy. Holding nmi_req high does not cause a second acceptance.
- R10: When a latched non-maskable request and an enabled maskable request meet at the same boundary, only the non-maskable one is acknowledged.
- R11: The return command (same for both return-from-interrupt forms) copies the saved enable into the live enable.
- R12: The acknowledge strobe is high for one cycle, in the cycle after the accepting boundary. The device byte is sampled during that cycle. vec_valid is high for one cycle in the cycle after that, with vec_kind and vec_addr valid.
- R13: halt_exit pulses together with the acknowledge strobe when halted was high at the accepting boundary. A request that is not accepted gives no halt_exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_ei | input | 1 | Enable-interrupts command strobe |
| cmd_di | input | 1 | Disable-interrupts command strobe |
| cmd_ret | input | 1 | Return-from-interrupt command strobe |
| cmd_im | input | 1 | Set-mode command strobe |
| im_field | input | 2 | Opcode bits 4:3 of the set-mode instruction |
| cmd_ld_i | input | 1 | Load-base command strobe |
| i_wdata | input | DATA_W | Value for the base register |
| boundary | input | 1 | Instruction-boundary pulse |
| halted | input | 1 | Core is in the halted state |
| int_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| dev_byte | input | DATA_W | Byte driven by the device during acknowledge |
| ack_int | output | 1 | Maskable acknowledge strobe |
| ack_nmi | output | 1 | Non-maskable acknowledge strobe |
| halt_exit | output | 1 | Leave the halted state |
| vec_valid | output | 1 | Target outputs are valid |
| vec_kind | output | 2 | 0 jump, 1 table pointer, 2 execute byte |
| vec_addr | output | ADDR_W | Target address, table pointer or byte |

## Verification
The bench builds the block with its default parameters: an 8-bit device byte and base register and a 16-bit target. These widths are small enough to sweep every device byte under all four mode field values, and every base register value in table mode. Each of those acceptances also checks the one-boundary enable delay and the enable clearing on acceptance. Directed sequences cover the cases that need more state. These are edge-only capture of the non-maskable request, the saved enable surviving a non-maskable acceptance and being brought back by a return, priority when both requests meet at one boundary, and halt release for accepted and for masked requests.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt mode and enable controller.
// Assumes encodings are fixed by the requirements (vec_kind values 0/1/2).
package irq_pkg;

    typedef enum logic [1:0] {
        IM_DEV_BYTE = 2'd0,
        IM_FIXED    = 2'd1,
        IM_TABLE    = 2'd2
    } irq_mode_e;

    typedef enum logic [1:0] {
        TK_JUMP   = 2'd0,
        TK_TABLE  = 2'd1,
        TK_OPCODE = 2'd2
    } tgt_kind_e;

    // Map opcode bits 4:3 of the set-mode instruction onto a mode.
    function automatic irq_mode_e im_from_field(input logic [1:0] field);
        case (field)
            2'b10:   return IM_FIXED;
            2'b11:   return IM_TABLE;
            default: return IM_DEV_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/irq_enable_ff.sv
// Enable flip-flop pair with a one-boundary delay after the enable command.
// Assumes command strobes never coincide with a boundary pulse; acceptance
// events (take_int/take_nmi) have priority over commands if they ever do.
module irq_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic restore,
    input  logic boundary,
    input  logic take_int,
    input  logic take_nmi,
    output logic iff1,
    output logic iff2,
    output logic mask_open
);

    logic shadow_q;

    // Update the live and saved enables from acceptances and commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_int) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_nmi) begin
            iff1 <= 1'b0;
        end else if (clr_en) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (set_en) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end else if (restore) begin
            iff1 <= iff2;
        end
    end

    // Block maskable acceptance until the boundary that ends the enable instruction has passed.
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow_q <= 1'b0;
        else if (set_en)    shadow_q <= 1'b1;
        else if (boundary)  shadow_q <= 1'b0;
    end

    assign mask_open = iff1 & ~shadow_q;

endmodule

// File: rtl/irq_mode_store.sv
// Holds the vectoring mode and the vector base register.
// Assumes the decoder has already extracted the mode field from the opcode.
module irq_mode_store #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                im_wr,
    input  logic [1:0]          im_field,
    input  logic                base_wr,
    input  logic [DATA_W-1:0]   base_wdata,
    output irq_pkg::irq_mode_e  mode,
    output logic [DATA_W-1:0]   base
);

    // Mode register, written by the set-mode command.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode <= irq_pkg::IM_DEV_BYTE;
        else if (im_wr) mode <= irq_pkg::im_from_field(im_field);
    end

    // Base register, written by the load-base command.
    always_ff @(posedge clk) begin
        if (!rst_n)       base <= '0;
        else if (base_wr) base <= base_wdata;
    end

endmodule

// File: rtl/irq_accept_vec.sv
// Samples requests at boundaries, arbitrates, acknowledges and forms the target.
// Assumes ADDR_W equals twice DATA_W and no boundary arrives during acknowledge.
module irq_accept_vec #(
    parameter int                 DATA_W    = 8,
    parameter int                 ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]  FIXED_VEC = 16'h0038,
    parameter logic [ADDR_W-1:0]  NMI_VEC   = 16'h0066
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                boundary,
    input  logic                int_req,
    input  logic                nmi_req,
    input  logic                halted,
    input  logic                mask_open,
    input  irq_pkg::irq_mode_e  mode,
    input  logic [DATA_W-1:0]   base,
    input  logic [DATA_W-1:0]   dev_byte,
    output logic                take_int,
    output logic                take_nmi,
    output logic                ack_int,
    output logic                ack_nmi,
    output logic                halt_exit,
    output logic                vec_valid,
    output irq_pkg::tgt_kind_e  vec_kind,
    output logic [ADDR_W-1:0]   vec_addr
);

    logic               nmi_q;
    logic               nmi_pend;
    logic               nmi_rise;
    logic               busy;
    logic               sample;
    irq_pkg::irq_mode_e acc_mode;
    logic [DATA_W-1:0]  acc_base;

    assign nmi_rise = nmi_req & ~nmi_q;
    assign busy     = ack_int | ack_nmi;
    assign sample   = boundary & ~busy;
    assign take_nmi = sample & nmi_pend;
    assign take_int = sample & ~nmi_pend & int_req & mask_open;

    // Latch a rising edge of the non-maskable request until it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_req;
            if (nmi_rise)      nmi_pend <= 1'b1;
            else if (take_nmi) nmi_pend <= 1'b0;
        end
    end

    // Acknowledge stage: strobes, halt release and the context for the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_int   <= 1'b0;
            ack_nmi   <= 1'b0;
            halt_exit <= 1'b0;
            acc_mode  <= irq_pkg::IM_DEV_BYTE;
            acc_base  <= '0;
        end else begin
            ack_int   <= take_int;
            ack_nmi   <= take_nmi;
            halt_exit <= (take_int | take_nmi) & halted;
            if (take_int | take_nmi) begin
                acc_mode <= mode;
                acc_base <= base;
            end
        end
    end

    // Vector stage: combine the captured mode with the byte sampled during acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_kind  <= irq_pkg::TK_JUMP;
            vec_addr  <= '0;
        end else begin
            vec_valid <= busy;
            if (ack_nmi) begin
                vec_kind <= irq_pkg::TK_JUMP;
                vec_addr <= NMI_VEC;
            end else if (ack_int) begin
                case (acc_mode)
                    irq_pkg::IM_FIXED: begin
                        vec_kind <= irq_pkg::TK_JUMP;
                        vec_addr <= FIXED_VEC;
                    end
                    irq_pkg::IM_TABLE: begin
                        vec_kind <= irq_pkg::TK_TABLE;
                        vec_addr <= ADDR_W'({acc_base, dev_byte});
                    end
                    default: begin
                        vec_kind <= irq_pkg::TK_OPCODE;
                        vec_addr <= ADDR_W'(dev_byte);
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_mode_ctrl.sv
// Top of the interrupt mode and enable controller: wires the enable pair,
// the mode/base store and the accept/vector pipeline together.
// Assumes decoder strobes are single-cycle and never share a cycle with boundary.
module irq_mode_ctrl #(
    parameter int                 DATA_W    = 8,
    parameter int                 ADDR_W    = 2 * DATA_W,
    parameter logic [ADDR_W-1:0]  FIXED_VEC = 16'h0038,
    parameter logic [ADDR_W-1:0]  NMI_VEC   = 16'h0066
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_ei,
    input  logic              cmd_di,
    input  logic              cmd_ret,
    input  logic              cmd_im,
    input  logic [1:0]        im_field,
    input  logic              cmd_ld_i,
    input  logic [DATA_W-1:0] i_wdata,
    input  logic              boundary,
    input  logic              halted,
    input  logic              int_req,
    input  logic              nmi_req,
    input  logic [DATA_W-1:0] dev_byte,
    output logic              ack_int,
    output logic              ack_nmi,
    output logic              halt_exit,
    output logic              vec_valid,
    output logic [1:0]        vec_kind,
    output logic [ADDR_W-1:0] vec_addr
);

    logic               iff1_q;
    logic               iff2_q;
    logic               mask_open;
    logic               take_int;
    logic               take_nmi;
    irq_pkg::irq_mode_e mode_q;
    logic [DATA_W-1:0]  base_q;
    irq_pkg::tgt_kind_e kind_q;

    irq_enable_ff u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (cmd_ei),
        .clr_en    (cmd_di),
        .restore   (cmd_ret),
        .boundary  (boundary),
        .take_int  (take_int),
        .take_nmi  (take_nmi),
        .iff1      (iff1_q),
        .iff2      (iff2_q),
        .mask_open (mask_open)
    );

    irq_mode_store #(.DATA_W(DATA_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .im_wr      (cmd_im),
        .im_field   (im_field),
        .base_wr    (cmd_ld_i),
        .base_wdata (i_wdata),
        .mode       (mode_q),
        .base       (base_q)
    );

    irq_accept_vec #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .FIXED_VEC (FIXED_VEC),
        .NMI_VEC   (NMI_VEC)
    ) u_accept (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .int_req   (int_req),
        .nmi_req   (nmi_req),
        .halted    (halted),
        .mask_open (mask_open),
        .mode      (mode_q),
        .base      (base_q),
        .dev_byte  (dev_byte),
        .take_int  (take_int),
        .take_nmi  (take_nmi),
        .ack_int   (ack_int),
        .ack_nmi   (ack_nmi),
        .halt_exit (halt_exit),
        .vec_valid (vec_valid),
        .vec_kind  (kind_q),
        .vec_addr  (vec_addr)
    );

    assign vec_kind = kind_q;

endmodule

// File: rtl/irq_mode_ctrl_chk.sv
// Property checker for irq_mode_ctrl, attached by bind below.
// Assumes the same command/boundary separation as the design.
module irq_mode_ctrl_chk #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ei,
    input logic              cmd_di,
    input logic              cmd_ret,
    input logic              boundary,
    input logic              ack_int,
    input logic              ack_nmi,
    input logic              halt_exit,
    input logic              vec_valid,
    input logic [ADDR_W-1:0] vec_addr,
    input logic              iff1,
    input logic              iff2
);

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_int && ack_nmi)); // R10

    AST_ACK_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_int || ack_nmi) |-> $past(boundary)); // R12

    AST_VEC_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_int || ack_nmi) |=> vec_valid); // R12

    AST_VEC_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_int || ack_nmi)); // R12

    AST_NMI_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |=> (vec_addr == NMI_VEC)); // R9

    AST_NMI_KEEPS_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> (!iff1 && iff2 == $past(iff2))); // R9

    AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> $past(iff1)); // R2

    AST_INT_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> (!iff1 && !iff2)); // R8

    AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_ret && !cmd_ei && !cmd_di && !boundary) |-> (iff1 == $past(iff2))); // R11

    AST_HALT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        halt_exit |-> (ack_int || ack_nmi)); // R13

endmodule

bind irq_mode_ctrl irq_mode_ctrl_chk #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ei    (cmd_ei),
    .cmd_di    (cmd_di),
    .cmd_ret   (cmd_ret),
    .boundary  (boundary),
    .ack_int   (ack_int),
    .ack_nmi   (ack_nmi),
    .halt_exit (halt_exit),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .iff1      (iff1_q),
    .iff2      (iff2_q)
);

// File: tb/sim_irq_mode_ctrl.sv
module sim_irq_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_ei = 1'b0, cmd_di = 1'b0, cmd_ret = 1'b0, cmd_im = 1'b0, cmd_ld_i = 1'b0;
    logic [1:0]  im_field = 2'b00;
    logic [7:0]  i_wdata = 8'h00;
    logic        boundary = 1'b0, halted = 1'b0, int_req = 1'b0, nmi_req = 1'b0;
    logic [7:0]  dev_byte = 8'h00;
    logic        ack_int, ack_nmi, halt_exit, vec_valid;
    logic [1:0]  vec_kind;
    logic [15:0] vec_addr;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    irq_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_ret(cmd_ret),
        .cmd_im(cmd_im), .im_field(im_field), .cmd_ld_i(cmd_ld_i), .i_wdata(i_wdata),
        .boundary(boundary), .halted(halted), .int_req(int_req), .nmi_req(nmi_req),
        .dev_byte(dev_byte), .ack_int(ack_int), .ack_nmi(ack_nmi), .halt_exit(halt_exit),
        .vec_valid(vec_valid), .vec_kind(vec_kind), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_ei();  cmd_ei = 1'b1;  @(negedge clk); cmd_ei = 1'b0;  endtask
    task automatic do_di();  cmd_di = 1'b1;  @(negedge clk); cmd_di = 1'b0;  endtask
    task automatic do_ret(); cmd_ret = 1'b1; @(negedge clk); cmd_ret = 1'b0; endtask
    task automatic do_im(input logic [1:0] f);
        im_field = f; cmd_im = 1'b1; @(negedge clk); cmd_im = 1'b0;
    endtask
    task automatic do_ldi(input logic [7:0] v);
        i_wdata = v; cmd_ld_i = 1'b1; @(negedge clk); cmd_ld_i = 1'b0;
    endtask

    // One boundary, then the acknowledge cycle, then the vector cycle.
    task automatic probe(input string req, input bit e_int, input bit e_nmi, input bit e_halt,
                         input logic [7:0] byt, input logic [1:0] kind, input logic [15:0] addr);
        boundary = 1'b1; dev_byte = ~byt;
        @(negedge clk);
        boundary = 1'b0; dev_byte = byt;
        chk(req, "ack_int", 32'(ack_int), 32'(e_int));
        chk(req, "ack_nmi", 32'(ack_nmi), 32'(e_nmi));
        chk(req, "halt_exit", 32'(halt_exit), 32'(e_halt));
        chk("R12", "vec_valid in ack cycle", 32'(vec_valid), 32'd0);
        @(negedge clk);
        dev_byte = 8'h00;
        chk(e_int || e_nmi ? "R12" : req, "vec_valid", 32'(vec_valid), 32'(e_int | e_nmi));
        chk("R12", "ack one cycle", 32'(ack_int | ack_nmi), 32'd0);
        if (e_int || e_nmi) begin
            chk(req, "vec_kind", 32'(vec_kind), 32'(kind));
            chk(req, "vec_addr", 32'(vec_addr), 32'(addr));
        end
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ack_int", 32'(ack_int), 32'd0);
        chk("R1", "ack_nmi", 32'(ack_nmi), 32'd0);
        chk("R1", "vec_valid", 32'(vec_valid), 32'd0);
        chk("R1", "halt_exit", 32'(halt_exit), 32'd0);
        chk("R1", "vec_addr", 32'(vec_addr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: enables clear after reset
        int_req = 1'b1;
        probe("R1", 0, 0, 0, 8'h11, 2'd0, 16'h0);

        // R1, R7: base is 00h after reset; R3 one-boundary delay
        do_im(2'b11);
        do_ei();
        probe("R3", 0, 0, 0, 8'h22, 2'd0, 16'h0);
        probe("R1", 1, 0, 0, 8'hA4, 2'd1, 16'h00A4);

        // R8: acceptance clears both, return does not re-enable
        probe("R8", 0, 0, 0, 8'h33, 2'd0, 16'h0);
        do_ret();
        probe("R8", 0, 0, 0, 8'h33, 2'd0, 16'h0);

        // R4/R5/R6/R7: every mode field value against every device byte
        do_ldi(8'h3C);
        for (int f = 0; f < 4; f++) begin
            for (int b = 0; b < 256; b++) begin
                do_im(2'(f));
                do_ei();
                probe("R3", 0, 0, 0, 8'(b), 2'd0, 16'h0);
                if (f == 2)      probe("R6", 1, 0, 0, 8'(b), 2'd0, 16'h0038);
                else if (f == 3) probe("R7", 1, 0, 0, 8'(b), 2'd1, {8'h3C, 8'(b)});
                else             probe("R5", 1, 0, 0, 8'(b), 2'd2, {8'h00, 8'(b)});
            end
        end

        // R7: every base register value in table mode
        do_im(2'b11);
        for (int i = 0; i < 256; i++) begin
            do_ldi(8'(i));
            do_ei();
            probe("R3", 0, 0, 0, 8'h00, 2'd0, 16'h0);
            probe("R7", 1, 0, 0, ~8'(i), 2'd1, {8'(i), ~8'(i)});
        end

        // R2: disable clears enables
        do_ei();
        probe("R3", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        do_di();
        probe("R2", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        do_ei();
        do_di();
        probe("R2", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        probe("R2", 0, 0, 0, 8'h00, 2'd0, 16'h0);

        // R9: edge captured regardless of enables, level does not retrigger
        int_req = 1'b0;
        nmi_req = 1'b1;
        @(negedge clk);
        probe("R9", 0, 1, 0, 8'h77, 2'd0, 16'h0066);
        probe("R9", 0, 0, 0, 8'h77, 2'd0, 16'h0);
        nmi_req = 1'b0;
        @(negedge clk);

        // R9, R11: non-maskable keeps saved enable, return restores it
        do_im(2'b10);
        do_ei();
        probe("R3", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        nmi_req = 1'b1;
        @(negedge clk);
        probe("R9", 0, 1, 0, 8'h55, 2'd0, 16'h0066);
        nmi_req = 1'b0;
        int_req = 1'b1;
        probe("R9", 0, 0, 0, 8'h55, 2'd0, 16'h0);
        do_ret();
        probe("R11", 1, 0, 0, 8'h55, 2'd0, 16'h0038);

        // R10: both requests at one boundary
        int_req = 1'b0;
        do_ei();
        probe("R3", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        int_req = 1'b1;
        nmi_req = 1'b1;
        @(negedge clk);
        probe("R10", 0, 1, 0, 8'h99, 2'd0, 16'h0066);
        nmi_req = 1'b0;
        probe("R10", 0, 0, 0, 8'h99, 2'd0, 16'h0);
        do_ret();
        probe("R11", 1, 0, 0, 8'h99, 2'd0, 16'h0038);

        // R13: halt release
        halted = 1'b1;
        int_req = 1'b0;
        do_ei();
        probe("R13", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        int_req = 1'b1;
        probe("R13", 1, 0, 1, 8'h00, 2'd0, 16'h0038);
        probe("R13", 0, 0, 0, 8'h00, 2'd0, 16'h0);
        nmi_req = 1'b1;
        @(negedge clk);
        probe("R13", 0, 1, 1, 8'h00, 2'd0, 16'h0066);
        nmi_req = 1'b0;
        halted = 1'b0;
        int_req = 1'b0;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule